// File: doc/BRIEF.md
# Static Memory Bank Timing Controller

This block drives an external parallel memory bus with an 8-bit data path and several chip-select banks. Each bank has a timing word that sets five intervals in clock cycles: address setup before the strobe, strobe width, address hold after the strobe, recovery time after the access, and an extra turnaround gap that applies only when an access moves to a different bank. The strobe-width and turnaround fields use a compressed 4-bit code. Codes 0 to 10 mean that many cycles. Codes 11 to 15 mean 12, 15, 20, 25 and 31 cycles.

A host register port programs the timing words and a mode register. The mode register can mark a bank as NAND-type. A request to such a bank is refused. For a bank marked this way, a software chip-enable bit drives the bank's chip-select pin directly. A request port carries a bank number, an address, a direction and write data. It starts one access, sequences the chip selects, the read and write strobes and the address on the pins, and then reports completion with a one-cycle done pulse. For reads, the captured byte is returned with that pulse.

Top module: `sbc_top`

## Requirements
- R1: After reset every bank timing word reads back with each timing field at its slowest code (setup and hold clamped to SETUP_HOLD_MAX), the mode register reads zero, all chip selects and strobes are high and busy is low.
- R2: Bank n (numbered from 1) has its timing word at host offset 0x14 + 4*(n-1): setup in bits 11:8, hold in bits 15:12, turnaround code in bits 19:16, strobe code in bits 23:20, recovery in bits 29:24. Bit 0 and bits 7:6 always read zero, so the bank is always plain SRAM with an 8-bit width.
- R3: A setup or hold value written above SETUP_HOLD_MAX is stored as SETUP_HOLD_MAX.
- R4: The strobe and turnaround codes 0..10 stand for that many cycles, and codes 11, 12, 13, 14 and 15 stand for 12, 15, 20, 25 and 31 cycles.
- R5: An accepted access runs these phases in order. Turnaround (chip selects high). Setup for `setup` cycles (chip select low, strobe high). Strobe for decoded strobe code + 1 cycles. Hold for `hold` cycles (chip select low). Recovery for `recov` cycles (chip select high). Done is then high in the next cycle, so done comes gap+setup+strobe+1+hold+recov+1 cycles after the accepting edge.
- R6: The turnaround gap applies only when the bank differs from the bank of the previous successful access. The first access after reset has no gap.
- R7: A read asserts the output-enable strobe. It captures the bus input on the last strobe cycle and presents the byte on rd_data while done is high.
- R8: A write asserts the write strobe and drives the data with its output enable high during setup, strobe and hold. The two strobes are never low together, and a strobe is low only while exactly one sequenced chip select is low.
- R9: A request to a bank marked NAND, or to bank 0 or to a bank above NUM_BANKS, gives done and err together in the cycle after it is accepted. No chip select or strobe goes low for it.
- R10: In the mode register at offset 0x50, bit 2*(n-1) marks bank n as NAND and bit 2*(n-1)+1 is its software chip enable. The enable drives mem_cs_n of bank n low only while the NAND bit is set. Bits 31:16 always read zero.
- R11: busy is high from acceptance through the done cycle. Requests made while busy are ignored. done lasts exactly one cycle.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register contents at host_addr |
| req_valid | input | 1 | Access request (taken when not busy) |
| req_bank | input | 4 | Bank number, 1-based |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Memory address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Refused request, valid with done |
| rd_data | output | 8 | Read byte, valid with done |
| mem_cs_n | output | NUM_BANKS | Active-low chip selects |
| mem_addr | output | ADDR_W | Address pins |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_dout | output | 8 | Data out to the bus |
| mem_dout_en | output | 1 | Data output enable |
| mem_din | input | 8 | Data in from the bus |

## Verification
The following rules are checked every cycle:
- done is a single pulse.
- The two strobes never overlap.
- A strobe is low only under a single sequenced chip select.
- A latched request stays stable while busy.
- Stored setup and hold values never exceed their limit.

The exact phase lengths, the code decoding, the conditional turnaround gap, read-data capture, refusal of NAND-marked banks and the effect of the chip-enable bit can only be shown by the bench's scenarios. The bench counts cycles from acceptance to done, counts strobe-low and chip-select-low cycles, and writes and reads back data through a memory model.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    localparam int BANK_W = 4;
    localparam int CNT_W  = 7;
    localparam logic [7:0] BANK_BASE = 8'h14;
    localparam logic [7:0] MODE_OFS  = 8'h50;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_GAP    = 3'd1,
        PH_SETUP  = 3'd2,
        PH_STROBE = 3'd3,
        PH_HOLD   = 3'd4,
        PH_RECOV  = 3'd5,
        PH_DONE   = 3'd6
    } phase_e;

    typedef struct packed {
        logic [5:0] recov;
        logic [3:0] wait_code;
        logic [3:0] gap_code;
        logic [3:0] hold;
        logic [3:0] setup;
    } bank_timing_t;

    // compressed 4-bit interval code to cycles
    function automatic logic [4:0] decode_span(input logic [3:0] code);
        case (code)
            4'd11:   return 5'd12;
            4'd12:   return 5'd15;
            4'd13:   return 5'd20;
            4'd14:   return 5'd25;
            4'd15:   return 5'd31;
            default: return {1'b0, code};
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] phase_len(input phase_e p, input bank_timing_t t,
                                                   input logic gap_en);
        case (p)
            PH_GAP:    return gap_en ? {2'b0, decode_span(t.gap_code)} : '0;
            PH_SETUP:  return {3'b0, t.setup};
            PH_STROBE: return {2'b0, decode_span(t.wait_code)} + 7'd1;
            PH_HOLD:   return {3'b0, t.hold};
            PH_RECOV:  return {1'b0, t.recov};
            default:   return 7'd1;
        endcase
    endfunction

    function automatic logic [31:0] pack_timing(input bank_timing_t t);
        return {2'b00, t.recov, t.wait_code, t.gap_code, t.hold, t.setup, 8'h00};
    endfunction

endpackage

// File: rtl/sbc_regs.sv
module sbc_regs
    import sbc_pkg::*;
#(
    parameter int NUM_BANKS      = 4,
    parameter int SETUP_HOLD_MAX = 15
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           host_we,
    input  logic [7:0]                     host_addr,
    input  logic [31:0]                    host_wdata,
    output logic [31:0]                    host_rdata,
    output bank_timing_t [NUM_BANKS-1:0]   cfg,
    output logic [NUM_BANKS-1:0]           nand_mask,
    output logic [NUM_BANKS-1:0]           ce_mask
);

    localparam logic [3:0] SH_CAP = 4'(SETUP_HOLD_MAX);

    typedef struct packed {
        bank_timing_t [NUM_BANKS-1:0] bank;
        logic [NUM_BANKS-1:0]         nand_bit;
        logic [NUM_BANKS-1:0]         ce_bit;
    } regs_t;

    regs_t q, d;

    function automatic logic [3:0] sat(input logic [3:0] v);
        return (v > SH_CAP) ? SH_CAP : v;
    endfunction

    always_comb begin
        d = q;
        host_rdata = '0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            if (host_addr == 8'(BANK_BASE + 8'(4 * k))) begin
                host_rdata = pack_timing(q.bank[k]);
                if (host_we) begin
                    d.bank[k].setup     = sat(host_wdata[11:8]);
                    d.bank[k].hold      = sat(host_wdata[15:12]);
                    d.bank[k].gap_code  = host_wdata[19:16];
                    d.bank[k].wait_code = host_wdata[23:20];
                    d.bank[k].recov     = host_wdata[29:24];
                end
            end
        end
        if (host_addr == MODE_OFS) begin
            for (int k = 0; k < NUM_BANKS; k++) begin
                host_rdata[2*k]   = q.nand_bit[k];
                host_rdata[2*k+1] = q.ce_bit[k];
                if (host_we) begin
                    d.nand_bit[k] = host_wdata[2*k];
                    d.ce_bit[k]   = host_wdata[2*k+1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_BANKS; k++) begin
                q.bank[k] <= '{recov: 6'h3F, wait_code: 4'hF, gap_code: 4'hF,
                               hold: SH_CAP, setup: SH_CAP};
            end
            q.nand_bit <= '0;
            q.ce_bit   <= '0;
        end else begin
            q <= d;
        end
    end

    assign cfg       = q.bank;
    assign nand_mask = q.nand_bit;
    assign ce_mask   = q.ce_bit;

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_cap
        // R3
        setup_hold_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q.bank[k].setup <= SH_CAP) && (q.bank[k].hold <= SH_CAP));
    end

endmodule

// File: rtl/sbc_seq.sv
module sbc_seq
    import sbc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  bank_timing_t [NUM_BANKS-1:0] cfg,
    input  logic [NUM_BANKS-1:0]         nand_mask,
    input  logic                         req_valid,
    input  logic [BANK_W-1:0]            req_bank,
    input  logic                         req_write,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [7:0]                   req_wdata,
    output logic                         busy,
    output logic                         done,
    output logic                         err,
    output logic [7:0]                   rd_data,
    output logic [NUM_BANKS-1:0]         sel,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic                         we_n,
    output logic                         oe_n,
    output logic [7:0]                   mem_dout,
    output logic                         dout_en,
    input  logic [7:0]                   mem_din
);

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        logic [BANK_W-1:0]   bank;
        logic [BANK_W-1:0]   last;
        logic [ADDR_W-1:0]   addr;
        logic [7:0]          wdata;
        logic                write;
        logic [7:0]          rdata;
        logic                err;
    } seq_t;

    seq_t q, d;

    bank_timing_t req_cfg, cur_cfg, t_sel;
    logic         req_ok, req_nand, go, gap_en;
    logic [2:0]   p;

    always_comb begin
        req_cfg  = '0;
        cur_cfg  = '0;
        req_nand = 1'b0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            if (req_bank == BANK_W'(k + 1)) begin
                req_cfg  = cfg[k];
                req_nand = nand_mask[k];
            end
            if (q.bank == BANK_W'(k + 1)) cur_cfg = cfg[k];
        end
        req_ok = (req_bank != '0) && (int'(req_bank) <= NUM_BANKS);
    end

    always_comb begin
        d      = q;
        go     = 1'b0;
        gap_en = 1'b0;
        t_sel  = cur_cfg;
        p      = 3'(PH_GAP);
        case (q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    if (!req_ok || req_nand) begin
                        d.phase = PH_DONE;
                        d.cnt   = 7'd1;
                        d.err   = 1'b1;
                    end else begin
                        d.bank  = req_bank;
                        d.last  = req_bank;
                        d.addr  = req_addr;
                        d.wdata = req_wdata;
                        d.write = req_write;
                        d.err   = 1'b0;
                        go      = 1'b1;
                        t_sel   = req_cfg;
                        gap_en  = (q.last != '0) && (q.last != req_bank);
                    end
                end
            end
            PH_DONE: d.phase = PH_IDLE;
            default: begin
                if (q.phase == PH_STROBE && q.cnt == 7'd1 && !q.write) d.rdata = mem_din;
                if (q.cnt <= 7'd1) begin
                    go = 1'b1;
                    p  = 3'(q.phase) + 3'd1;
                end else begin
                    d.cnt = q.cnt - 7'd1;
                end
            end
        endcase
        if (go) begin
            for (int i = 0; i < 5; i++) begin
                if (p != 3'(PH_DONE) && phase_len(phase_e'(p), t_sel, gap_en) == '0)
                    p = p + 3'd1;
            end
            d.phase = phase_e'(p);
            d.cnt   = phase_len(phase_e'(p), t_sel, gap_en);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    logic active;
    assign active   = (q.phase == PH_SETUP) || (q.phase == PH_STROBE) || (q.phase == PH_HOLD);
    assign busy     = (q.phase != PH_IDLE);
    assign done     = (q.phase == PH_DONE);
    assign err      = done && q.err;
    assign rd_data  = q.rdata;
    assign mem_addr = q.addr;
    assign mem_dout = q.wdata;
    assign dout_en  = active && q.write;
    assign we_n     = !((q.phase == PH_STROBE) && q.write);
    assign oe_n     = !((q.phase == PH_STROBE) && !q.write);

    always_comb begin
        sel = '0;
        for (int k = 0; k < NUM_BANKS; k++)
            sel[k] = active && (q.bank == BANK_W'(k + 1));
    end

    // R11
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));
    // R8
    strobe_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !oe_n) |-> ($countones(sel) == 1));
    // R11
    request_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(mem_addr) && $stable(mem_dout)));

endmodule

// File: rtl/sbc_top.sv
module sbc_top
    import sbc_pkg::*;
#(
    parameter int NUM_BANKS      = 4,
    parameter int ADDR_W         = 16,
    parameter int SETUP_HOLD_MAX = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_we,
    input  logic [7:0]           host_addr,
    input  logic [31:0]          host_wdata,
    output logic [31:0]          host_rdata,
    input  logic                 req_valid,
    input  logic [3:0]           req_bank,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [7:0]           req_wdata,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic [7:0]           rd_data,
    output logic [NUM_BANKS-1:0] mem_cs_n,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_we_n,
    output logic                 mem_oe_n,
    output logic [7:0]           mem_dout,
    output logic                 mem_dout_en,
    input  logic [7:0]           mem_din
);

    bank_timing_t [NUM_BANKS-1:0] cfg;
    logic [NUM_BANKS-1:0]         nand_mask, ce_mask, sel;

    sbc_regs #(.NUM_BANKS(NUM_BANKS), .SETUP_HOLD_MAX(SETUP_HOLD_MAX)) regs_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .cfg(cfg),
        .nand_mask(nand_mask), .ce_mask(ce_mask)
    );

    sbc_seq #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .nand_mask(nand_mask),
        .req_valid(req_valid), .req_bank(req_bank), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .err(err), .rd_data(rd_data), .sel(sel), .mem_addr(mem_addr),
        .we_n(mem_we_n), .oe_n(mem_oe_n), .mem_dout(mem_dout),
        .dout_en(mem_dout_en), .mem_din(mem_din)
    );

    assign mem_cs_n = ~(sel | (nand_mask & ce_mask));

    // R10
    cs_only_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~mem_cs_n) > $countones(sel)) |-> ((nand_mask & ce_mask) != '0));

endmodule

// File: tb/sbc_top_tb_top.sv
module sbc_top_tb_top;

    localparam int NB = 4;
    localparam int AW = 16;
    localparam int SHM = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_we = 1'b0;
    logic [7:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic req_valid = 1'b0;
    logic [3:0] req_bank = '0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic busy, done, err;
    logic [7:0] rd_data;
    logic [NB-1:0] mem_cs_n;
    logic [AW-1:0] mem_addr;
    logic mem_we_n, mem_oe_n, mem_dout_en;
    logic [7:0] mem_dout, mem_din;

    always #5 clk = ~clk;

    sbc_top #(.NUM_BANKS(NB), .ADDR_W(AW), .SETUP_HOLD_MAX(SHM)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .req_valid(req_valid),
        .req_bank(req_bank), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .err(err),
        .rd_data(rd_data), .mem_cs_n(mem_cs_n), .mem_addr(mem_addr),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .mem_din(mem_din)
    );

    logic [7:0] mem [256];
    always @(posedge clk) if (!mem_we_n) mem[mem_addr[7:0]] <= mem_dout;
    assign mem_din = mem[mem_addr[7:0]];

    int checks = 0;
    int fails = 0;

    // bank index 1..4 timing shadows
    int ts[5], th[5], tg[5], tw[5], tr[5];
    logic [7:0] shadow [256];
    int last_bank = 0;

    // vector: bank[23:20], write[16], addr[15:8], data[7:0]
    localparam logic [23:0] VEC [8] = '{
        24'h1_1_10_5A, 24'h1_0_10_00, 24'h2_1_20_C3, 24'h2_0_20_00,
        24'h3_1_30_77, 24'h1_0_10_00, 24'h4_0_20_00, 24'h3_0_30_00
    };

    function automatic int span(input int code);
        if (code <= 10) return code;
        case (code)
            11: return 12;
            12: return 15;
            13: return 20;
            14: return 25;
            default: return 31;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic access(input int b, input bit wr, input logic [7:0] a, input logic [7:0] dat,
                          output int n, output int strb, output int csl,
                          output logic [7:0] rd, output logic e);
        @(negedge clk);
        req_valid = 1'b1; req_bank = 4'(b); req_write = wr;
        req_addr = AW'(a); req_wdata = dat;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1; strb = 0; csl = 0; rd = '0; e = 1'b0;
        while (!done && n < 600) begin
            if (!mem_we_n || !mem_oe_n) strb++;
            if (b >= 1 && b <= NB && !mem_cs_n[b-1]) csl++;
            @(negedge clk);
            n++;
        end
        rd = rd_data;
        e = err;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n, s, c;
        logic [7:0] rd;
        logic e;

        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'h00;
            shadow[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int k = 0; k < NB; k++) begin
            hread(8'(8'h14 + 4 * k), v);
            check(v == 32'h3FFF7700, "R1 timing word reset", v, 32'h3FFF7700);
        end
        hread(8'h50, v);
        check(v == 0, "R1 mode reset", v, 0);
        check(mem_cs_n == '1 && mem_we_n && mem_oe_n && !busy, "R1 pins idle",
              {mem_cs_n, mem_we_n, mem_oe_n, busy}, {4'hF, 3'b110});

        // program banks (R2)
        hwrite(8'h14, 32'h01231200); ts[1]=2; th[1]=1; tg[1]=3;  tw[1]=2;  tr[1]=1;
        hwrite(8'h18, 32'h00BB0000); ts[2]=0; th[2]=0; tg[2]=11; tw[2]=11; tr[2]=0;
        hwrite(8'h1C, 32'h05DF2100); ts[3]=1; th[3]=2; tg[3]=15; tw[3]=13; tr[3]=5;
        ts[4]=7; th[4]=7; tg[4]=15; tw[4]=15; tr[4]=63;
        hread(8'h18, v);
        check(v == 32'h00BB0000, "R2 readback bank2", v, 32'h00BB0000);
        hread(8'h1C, v);
        check(v == 32'h05DF2100, "R2 readback bank3", v, 32'h05DF2100);

        // vector walk: R4 R5 R6 R7 R8
        for (int i = 0; i < 8; i++) begin
            int b, g, expn;
            bit wr;
            logic [7:0] a, dv;
            b = int'(VEC[i][23:20]); wr = VEC[i][16]; a = VEC[i][15:8]; dv = VEC[i][7:0];
            g = (last_bank != 0 && last_bank != b) ? span(tg[b]) : 0;
            expn = g + ts[b] + span(tw[b]) + 1 + th[b] + tr[b] + 1;
            access(b, wr, a, dv, n, s, c, rd, e);
            check(n == expn, "R5 R6 done latency", n, expn);
            check(s == span(tw[b]) + 1, "R4 strobe width", s, span(tw[b]) + 1);
            check(c == ts[b] + span(tw[b]) + 1 + th[b], "R5 chip select span",
                  c, ts[b] + span(tw[b]) + 1 + th[b]);
            check(!e, "R9 no error on SRAM bank", e, 0);
            if (wr) shadow[a] = dv;
            else check(rd == shadow[a], "R7 R8 read data", rd, shadow[a]);
            last_bank = b;
        end

        // R3 clamp and fixed-zero bits
        hwrite(8'h20, 32'h0000FFC1);
        hread(8'h20, v);
        check(v == 32'h00007700, "R3 R2 setup hold clamp", v, 32'h00007700);

        // R10 upper bits read zero, NAND mark
        hwrite(8'h50, 32'hFFFF0004);
        hread(8'h50, v);
        check(v == 32'h00000004, "R10 mode readback", v, 32'h4);
        // R9 refused request on NAND bank
        access(2, 1'b1, 8'h60, 8'h99, n, s, c, rd, e);
        check(n == 1 && e, "R9 NAND refusal timing", {n, e}, {32'd1, 1'b1});
        check(s == 0 && c == 0 && mem[8'h60] == 8'h00, "R9 no bus activity", s + c, 0);
        check(mem_cs_n[1] == 1'b1, "R10 cs idle without enable", mem_cs_n, 4'hF);
        hwrite(8'h50, 32'h0000000C);
        #1 check(mem_cs_n == 4'b1101, "R10 software enable drives cs", mem_cs_n, 4'b1101);
        hwrite(8'h50, 32'h00000002);
        #1 check(mem_cs_n == 4'b1111, "R10 enable ignored for SRAM bank", mem_cs_n, 4'b1111);
        hwrite(8'h50, 32'h0);
        // R9 bank out of range
        access(0, 1'b0, 8'h10, 8'h00, n, s, c, rd, e);
        check(n == 1 && e && s == 0, "R9 bank zero refused", {n, e}, {32'd1, 1'b1});

        // R11 requests while busy ignored; done single pulse
        @(negedge clk);
        req_valid = 1'b1; req_bank = 4'd1; req_write = 1'b0; req_addr = AW'(8'h10);
        @(negedge clk);
        req_bank = 4'd3; req_write = 1'b1; req_addr = AW'(8'h40); req_wdata = 8'hEE;
        check(busy, "R11 busy after accept", busy, 1);
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        check(rd_data == 8'h5A, "R11 first request served", rd_data, 8'h5A);
        @(negedge clk);
        check(!done && !busy, "R11 done single pulse", {done, busy}, 0);
        repeat (80) @(negedge clk);
        check(mem[8'h40] == 8'h00 && mem_cs_n == 4'hF, "R11 busy request ignored",
              mem[8'h40], 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule